// File: doc/BRIEF.md
# Register Command List Executor

This block runs a list of packed 32-bit register commands that sits in host memory. The host first writes the list's base address into a base register. It then writes a control word that holds a start bit, a response-capture bit and the list length in bytes. The engine fetches the words one at a time over a simple request/response memory port. It decodes each word and applies it to a local 8-bit register file. A command can write under a mask, read a register back or check a register. When the list ends, the engine pulses a completion interrupt and shows an OK or FAIL result.

Each command word is laid out as follows. Bits 31:30 hold the operation, bits 29:16 the register address, bits 15:8 a bit mask and bits 7:0 the data byte. When response capture is on, read commands store their byte into a response buffer, one byte per read command, in list order. The host can then read the results without issuing any further commands. A stop input abandons a running list at any point.

Top module: `cmd_list_engine`

## Requirements
- R1: A configuration write with `cfg_sel`=0 loads the list base address. A write with `cfg_sel`=1 and bit 31 set starts a list, and `busy` is 1 from the next cycle. Words are fetched one at a time, in order, from base, base+4, base+8 and so on.
- R2: The number of commands is the length field (control bits 23:0) divided by four, rounded down, and limited to MAX_CMDS (default 16). A count of zero ends at once with `done_irq`, an OK result and no fetch.
- R3: Operation 2'b01 (write) sets the addressed register to (old & ~mask) | (data & mask). Bits where the mask is 0 keep their value.
- R4: Operation 2'b00 (read) with control bit 30 set stores the addressed register into response slot `rsp_count` and then increments `rsp_count`. With bit 30 clear, a read leaves the buffer and `rsp_count` untouched. `rsp_count` is cleared at each start.
- R5: Operation 2'b10 (check) continues when (reg & mask) equals (data & mask). Otherwise the list ends with `result_fail`=1, and no later command takes effect.
- R6: An address at or above REG_DEPTH (default 64), or operation 2'b11, ends the list with `result_fail`=1 and changes no register.
- R7: At the end of a list, `done_irq` is high for exactly one cycle, and `busy` falls in that same cycle. `result_fail` is 0 after a list that finishes without error.
- R8: `stop` while busy clears `busy` on the next edge. No `done_irq` is raised and no further fetch is issued.
- R9: Configuration writes (base or control) made while busy are ignored. The running list keeps its length and addresses and completes once.
- R10: After reset, `busy`, `done_irq`, `result_fail`, `mem_req` and `rsp_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects base register, 1 selects control register |
| cfg_wdata | input | 32 | Configuration write data |
| stop | input | 1 | Abort running list |
| mem_req | output | 1 | One-cycle fetch request |
| mem_addr | output | 32 | Byte address of word fetched |
| mem_rsp_valid | input | 1 | Fetch data valid |
| mem_rsp_data | input | 32 | Fetched command word |
| busy | output | 1 | List in progress |
| done_irq | output | 1 | One-cycle completion pulse |
| result_fail | output | 1 | Result of last list, 1 = FAIL |
| rsp_count | output | 5 | Number of captured read bytes |
| reg_rd_addr | input | 6 | Host register-file read address |
| reg_rd_data | output | 8 | Register value, one cycle after address |
| rsp_rd_idx | input | 4 | Response buffer read index |
| rsp_rd_data | output | 8 | Response byte, one cycle after index |

## Verification
The bench targets the following corner cases:
- Partial-mask writes: a merge that dropped the old bits would wipe the neighbouring fields.
- Register 63 and the first address past the file: a missing range check would write an aliased register 0 rather than failing.
- Read commands with capture off: a design that ignored bit 30 would still grow `rsp_count`.
- A failing check followed by a write: a design that did not end the list at the mismatch would still apply that write.
- Zero, unaligned and oversized lengths: a wrong divide or a missing clamp shows up as the wrong number of fetches.
- A control write while busy, and a stop in mid-list: a design that restarted or kept fetching would show extra fetches or a stray interrupt.

// File: rtl/cle_pkg.sv
package cle_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_CHECK = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  typedef struct packed {
    op_e         op;
    logic [13:0] addr;
    logic [7:0]  mask;
    logic [7:0]  data;
  } cmd_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WAIT = 2'b01,
    ST_EXEC = 2'b10
  } state_e;

  localparam int CTL_START_BIT = 31;
  localparam int CTL_AUTO_BIT  = 30;
  localparam int CTL_LEN_W     = 24;
endpackage

// File: rtl/cle_ram.sv
module cle_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  parameter int NRD   = 1,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [NRD-1:0][AW-1:0]   raddr,
  output logic [NRD-1:0][DW-1:0]   rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // one synchronous read port per requester
  for (genvar g = 0; g < NRD; g++) begin : g_rd
    logic [DW-1:0] q;
    always_ff @(posedge clk) q <= mem[raddr[g]];
    assign rdata[g] = q;
  end
endmodule

// File: rtl/cle_seq.sv
module cle_seq
  import cle_pkg::*;
#(
  parameter int REG_DEPTH = 64,
  parameter int MAX_CMDS  = 16,
  localparam int AW = $clog2(REG_DEPTH),
  localparam int BW = $clog2(MAX_CMDS),
  localparam int CW = $clog2(MAX_CMDS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          stop,
  output logic          mem_req,
  output logic [31:0]   mem_addr,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  output logic [AW-1:0] rf_raddr,
  input  logic [7:0]    rf_rdata,
  output logic          rf_we,
  output logic [AW-1:0] rf_waddr,
  output logic [7:0]    rf_wdata,
  output logic          rb_we,
  output logic [BW-1:0] rb_waddr,
  output logic [7:0]    rb_wdata,
  output logic          busy,
  output logic          done_irq,
  output logic          result_fail,
  output logic [CW-1:0] rsp_count
);
  state_e        state_q;
  logic [31:0]   base_q, addr_q, word_q;
  logic          auto_q, busy_q, done_q, fail_q, req_q;
  logic [CW-1:0] total_q, idx_q, rcnt_q;

  cmd_t cmd, rsp_cmd;
  assign cmd     = cmd_t'(word_q);
  assign rsp_cmd = cmd_t'(mem_rsp_data);

  // control word decode
  logic [CTL_LEN_W-3:0] words;
  logic [CW-1:0]        n_cmds;
  logic                 start_req;
  assign words     = cfg_wdata[CTL_LEN_W-1:2];
  assign n_cmds    = (words > (CTL_LEN_W-2)'(MAX_CMDS)) ? CW'(MAX_CMDS) : words[CW-1:0];
  assign start_req = cfg_we && cfg_sel && cfg_wdata[CTL_START_BIT] && (state_q == ST_IDLE);

  logic unused_ok;
  assign unused_ok = ^{cfg_wdata[29:24], cfg_wdata[1:0]};

  // command execution
  logic in_exec, addr_ok, check_bad, cmd_bad, last_cmd;
  assign in_exec   = (state_q == ST_EXEC) && !stop;
  assign addr_ok   = cmd.addr < 14'(REG_DEPTH);
  assign check_bad = (cmd.op == OP_CHECK) && ((rf_rdata & cmd.mask) != (cmd.data & cmd.mask));
  assign cmd_bad   = !addr_ok || (cmd.op == OP_RSVD) || check_bad;
  assign last_cmd  = (idx_q + 1'b1) == total_q;

  assign rf_raddr = rsp_cmd.addr[AW-1:0];
  assign rf_we    = in_exec && (cmd.op == OP_WRITE) && addr_ok;
  assign rf_waddr = cmd.addr[AW-1:0];
  assign rf_wdata = (rf_rdata & ~cmd.mask) | (cmd.data & cmd.mask);
  assign rb_we    = in_exec && (cmd.op == OP_READ) && addr_ok && auto_q;
  assign rb_waddr = rcnt_q[BW-1:0];
  assign rb_wdata = rf_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      addr_q  <= '0;
      word_q  <= '0;
      auto_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      req_q   <= 1'b0;
      total_q <= '0;
      idx_q   <= '0;
      rcnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      req_q  <= 1'b0;
      if (cfg_we && !cfg_sel && state_q == ST_IDLE) base_q <= cfg_wdata;
      case (state_q)
        ST_IDLE: begin
          if (start_req) begin
            fail_q  <= 1'b0;
            rcnt_q  <= '0;
            auto_q  <= cfg_wdata[CTL_AUTO_BIT];
            total_q <= n_cmds;
            idx_q   <= '0;
            if (n_cmds == '0) begin
              done_q <= 1'b1;
            end else begin
              busy_q  <= 1'b1;
              req_q   <= 1'b1;
              addr_q  <= base_q;
              state_q <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (stop) begin
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else if (mem_rsp_valid) begin
            word_q  <= mem_rsp_data;
            state_q <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          if (stop) begin
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            if (rb_we) rcnt_q <= rcnt_q + 1'b1;
            if (cmd_bad || last_cmd) begin
              fail_q  <= cmd_bad;
              done_q  <= 1'b1;
              busy_q  <= 1'b0;
              state_q <= ST_IDLE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              req_q   <= 1'b1;
              addr_q  <= addr_q + 32'd4;
              state_q <= ST_WAIT;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req     = req_q;
  assign mem_addr    = addr_q;
  assign busy        = busy_q;
  assign done_irq    = done_q;
  assign result_fail = fail_q;
  assign rsp_count   = rcnt_q;

  // R1: a fetch is only ever issued by a running list, one at a time
  assert_req_busy_R1: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);
  assert_single_req_R1: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  // R4: captured bytes never exceed the buffer
  assert_rsp_bound_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_count <= CW'(MAX_CMDS));
  // R5: a fail result only appears together with completion
  assert_fail_with_done_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(result_fail) |-> done_irq);
  // R6: an out-of-range address ends the list as FAIL
  assert_bad_addr_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EXEC && !stop && !addr_ok) |=> (done_irq && result_fail));
  // R7: completion is a single pulse and the engine is idle with it
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done_irq |=> !done_irq);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> !busy);
  // R8: stop drops busy without an interrupt
  assert_stop_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && stop) |=> (!busy && !done_irq));
endmodule

// File: rtl/cmd_list_engine.sv
module cmd_list_engine #(
  parameter int REG_DEPTH = 64,
  parameter int MAX_CMDS  = 16,
  localparam int AW = $clog2(REG_DEPTH),
  localparam int BW = $clog2(MAX_CMDS),
  localparam int CW = $clog2(MAX_CMDS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          stop,
  output logic          mem_req,
  output logic [31:0]   mem_addr,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  output logic          busy,
  output logic          done_irq,
  output logic          result_fail,
  output logic [CW-1:0] rsp_count,
  input  logic [AW-1:0] reg_rd_addr,
  output logic [7:0]    reg_rd_data,
  input  logic [BW-1:0] rsp_rd_idx,
  output logic [7:0]    rsp_rd_data
);
  logic [AW-1:0] rf_raddr, rf_waddr;
  logic [7:0]    rf_rdata, rf_wdata, rb_wdata;
  logic          rf_we, rb_we;
  logic [BW-1:0] rb_waddr;
  logic [1:0][AW-1:0] rf_ra;
  logic [1:0][7:0]    rf_rd;

  assign rf_ra       = {reg_rd_addr, rf_raddr};
  assign rf_rdata    = rf_rd[0];
  assign reg_rd_data = rf_rd[1];

  cle_seq #(.REG_DEPTH(REG_DEPTH), .MAX_CMDS(MAX_CMDS)) u_seq (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .stop(stop),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .rb_we(rb_we), .rb_waddr(rb_waddr), .rb_wdata(rb_wdata),
    .busy(busy), .done_irq(done_irq), .result_fail(result_fail),
    .rsp_count(rsp_count)
  );

  cle_ram #(.DW(8), .DEPTH(REG_DEPTH), .NRD(2)) u_regs (
    .clk(clk), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr(rf_ra), .rdata(rf_rd)
  );

  cle_ram #(.DW(8), .DEPTH(MAX_CMDS), .NRD(1)) u_rsp (
    .clk(clk), .we(rb_we), .waddr(rb_waddr), .wdata(rb_wdata),
    .raddr(rsp_rd_idx), .rdata(rsp_rd_data)
  );
endmodule

// File: tb/sim_cmd_list_engine.sv
module sim_cmd_list_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0, stop = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        mem_req, busy, done_irq, result_fail;
  logic [31:0] mem_addr;
  logic        rsp_v = 1'b0, p1 = 1'b0;
  logic [31:0] rsp_d = '0;
  logic [7:0]  a1 = '0;
  logic [4:0]  rsp_count;
  logic [5:0]  reg_rd_addr = '0;
  logic [7:0]  reg_rd_data, rsp_rd_data;
  logic [3:0]  rsp_rd_idx = '0;
  logic [31:0] mem [256];
  int          req_cnt = 0, done_cnt = 0, cyc = 0;
  int          checks = 0, errors = 0;
  logic        last_fail, last_busy;

  always #4 clk = ~clk;

  cmd_list_engine u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .stop(stop), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(rsp_v), .mem_rsp_data(rsp_d),
    .busy(busy), .done_irq(done_irq), .result_fail(result_fail), .rsp_count(rsp_count),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .rsp_rd_idx(rsp_rd_idx), .rsp_rd_data(rsp_rd_data)
  );

  // memory model: data returns two edges after the request
  always @(posedge clk) begin
    p1    <= mem_req;
    a1    <= mem_addr[9:2];
    rsp_v <= p1;
    rsp_d <= mem[a1];
    if (mem_req) req_cnt <= req_cnt + 1;
    if (done_irq) done_cnt <= done_cnt + 1;
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual %0d expected <100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] w(input logic [1:0] op, input int addr,
                                    input logic [7:0] mask, input logic [7:0] data);
    return {op, 14'(addr), mask, data};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start(input int base, input logic auto, input int len);
    cfg(1'b0, 32'(base));
    cfg(1'b1, {1'b1, auto, 6'b0, 24'(len)});
  endtask

  task automatic wait_done();
    int n = 0;
    while (done_irq !== 1'b1 && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk("R7 done seen", 32'(done_irq), 32'd1);
    last_fail = result_fail;
    last_busy = busy;
    chk("R7 busy low at done", 32'(busy), 32'd0);
    @(negedge clk);
    chk("R7 done one cycle", 32'(done_irq), 32'd0);
  endtask

  task automatic rdreg(input int a, output logic [7:0] d);
    @(negedge clk); reg_rd_addr = 6'(a);
    @(negedge clk); d = reg_rd_data;
  endtask

  task automatic rdrsp(input int i, output logic [7:0] d);
    @(negedge clk); rsp_rd_idx = 4'(i);
    @(negedge clk); d = rsp_rd_data;
  endtask

  task automatic t_reset();
    chk("R10 busy", 32'(busy), 0);
    chk("R10 done", 32'(done_irq), 0);
    chk("R10 fail", 32'(result_fail), 0);
    chk("R10 req", 32'(mem_req), 0);
    chk("R10 rsp_count", 32'(rsp_count), 0);
  endtask

  task automatic t_full_write();
    logic [7:0] d; int r0;
    mem[0] = w(2'b01, 3, 8'hFF, 8'hA5);
    mem[1] = w(2'b01, 5, 8'hFF, 8'h3C);
    mem[2] = w(2'b01, 63, 8'hFF, 8'h11);
    mem[3] = w(2'b01, 0, 8'hFF, 8'h12);
    r0 = req_cnt;
    start(32'h000, 1'b0, 16);
    chk("R1 busy after start", 32'(busy), 1);
    wait_done();
    chk("R7 ok result", 32'(last_fail), 0);
    chk("R1 fetch count", 32'(req_cnt - r0), 4);
    rdreg(3, d);  chk("R3 reg3", 32'(d), 32'hA5);
    rdreg(5, d);  chk("R3 reg5", 32'(d), 32'h3C);
    rdreg(63, d); chk("R3 reg63", 32'(d), 32'h11);
    rdreg(0, d);  chk("R3 reg0", 32'(d), 32'h12);
  endtask

  task automatic t_masked();
    logic [7:0] d;
    mem[16] = w(2'b01, 3, 8'h0F, 8'h72);
    mem[17] = w(2'b01, 5, 8'hF0, 8'hFF);
    start(32'h040, 1'b0, 8);
    wait_done();
    rdreg(3, d); chk("R3 masked low nibble", 32'(d), 32'hA2);
    rdreg(5, d); chk("R3 masked high nibble", 32'(d), 32'hFC);
  endtask

  task automatic t_read_auto();
    logic [7:0] d;
    mem[32] = w(2'b00, 3, 8'h00, 8'h00);
    mem[33] = w(2'b00, 5, 8'h00, 8'h00);
    mem[34] = w(2'b00, 63, 8'h00, 8'h00);
    start(32'h080, 1'b1, 12);
    wait_done();
    chk("R4 rsp_count", 32'(rsp_count), 3);
    rdrsp(0, d); chk("R4 slot0", 32'(d), 32'hA2);
    rdrsp(1, d); chk("R4 slot1", 32'(d), 32'hFC);
    rdrsp(2, d); chk("R4 slot2", 32'(d), 32'h11);
    // capture off: buffer and count untouched
    mem[48] = w(2'b00, 5, 8'h00, 8'h00);
    start(32'h0C0, 1'b0, 4);
    wait_done();
    chk("R4 no capture count", 32'(rsp_count), 0);
    rdrsp(0, d); chk("R4 slot0 kept", 32'(d), 32'hA2);
  endtask

  task automatic t_check();
    logic [7:0] d; int r0;
    mem[64] = w(2'b10, 3, 8'hF0, 8'hA0);
    mem[65] = w(2'b01, 7, 8'hFF, 8'h77);
    start(32'h100, 1'b0, 8);
    wait_done();
    chk("R5 match ok", 32'(last_fail), 0);
    rdreg(7, d); chk("R5 write after match", 32'(d), 32'h77);
    mem[80] = w(2'b10, 3, 8'hFF, 8'h00);
    mem[81] = w(2'b01, 7, 8'hFF, 8'h99);
    r0 = req_cnt;
    start(32'h140, 1'b0, 8);
    wait_done();
    chk("R5 mismatch fail", 32'(last_fail), 1);
    chk("R5 fetch stops", 32'(req_cnt - r0), 1);
    rdreg(7, d); chk("R5 later write dropped", 32'(d), 32'h77);
  endtask

  task automatic t_bad();
    logic [7:0] d;
    mem[96] = w(2'b01, 64, 8'hFF, 8'h55);
    start(32'h180, 1'b0, 4);
    wait_done();
    chk("R6 range fail", 32'(last_fail), 1);
    rdreg(0, d); chk("R6 no alias write", 32'(d), 32'h12);
    mem[112] = w(2'b11, 3, 8'hFF, 8'h00);
    mem[113] = w(2'b01, 3, 8'hFF, 8'h66);
    start(32'h1C0, 1'b0, 8);
    wait_done();
    chk("R6 reserved op fail", 32'(last_fail), 1);
    rdreg(3, d); chk("R6 reg3 unchanged", 32'(d), 32'hA2);
  endtask

  task automatic t_length();
    logic [7:0] d; int r0;
    r0 = req_cnt;
    start(32'h000, 1'b0, 0);
    wait_done();
    chk("R2 zero length ok", 32'(last_fail), 0);
    chk("R2 zero length no fetch", 32'(req_cnt - r0), 0);
    r0 = req_cnt;
    start(32'h000, 1'b0, 3);
    wait_done();
    chk("R2 length 3 no fetch", 32'(req_cnt - r0), 0);
    r0 = req_cnt;
    start(32'h040, 1'b0, 11);
    wait_done();
    chk("R2 length 11 two fetches", 32'(req_cnt - r0), 2);
    for (int i = 0; i < 20; i++) mem[128 + i] = w(2'b01, 10, 8'hFF, 8'(i));
    r0 = req_cnt;
    start(32'h200, 1'b0, 80);
    wait_done();
    chk("R2 clamp fetches", 32'(req_cnt - r0), 16);
    rdreg(10, d); chk("R2 last executed", 32'(d), 32'd15);
  endtask

  task automatic t_busy_ignore();
    int r0, d0;
    for (int i = 0; i < 4; i++) mem[160 + i] = w(2'b01, 9, 8'hFF, 8'(i));
    r0 = req_cnt; d0 = done_cnt;
    start(32'h280, 1'b0, 16);
    repeat (3) @(negedge clk);
    cfg(1'b0, 32'h000);
    cfg(1'b1, {1'b1, 1'b0, 6'b0, 24'd4});
    wait_done();
    repeat (10) @(negedge clk);
    chk("R9 fetch count kept", 32'(req_cnt - r0), 4);
    chk("R9 single completion", 32'(done_cnt - d0), 1);
  endtask

  task automatic t_stop();
    int r0, d0;
    for (int i = 0; i < 8; i++) mem[192 + i] = w(2'b01, 11, 8'hFF, 8'(i));
    d0 = done_cnt;
    start(32'h300, 1'b0, 32);
    repeat (6) @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R8 busy cleared", 32'(busy), 0);
    r0 = req_cnt;
    repeat (30) @(negedge clk);
    chk("R8 no fetch after stop", 32'(req_cnt - r0), 0);
    chk("R8 no interrupt", 32'(done_cnt - d0), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_write();
    t_masked();
    t_read_auto();
    t_check();
    t_bad();
    t_length();
    t_busy_ignore();
    t_stop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule